// File: doc/BRIEF.md
# Expanding Opcode Instruction Decoder

This block decodes 16-bit instruction words for a machine with sixteen general registers. The opcode length is not fixed. A short opcode leaves room for three 4-bit register fields. Each escape prefix of all-ones nibbles makes the opcode longer and leaves one register field fewer. The deepest class uses the whole word as its opcode. There are four classes: 15 three-register, 14 two-register, 31 one-register and 16 no-register instructions. Together they occupy 61440 + 3584 + 496 + 16 = 65536 patterns, so every 16-bit value names exactly one instruction.

An upstream fetch stage presents a word with a valid strobe. The decoder reports four results one clock later, through a single register stage: the format class, a dense instruction number from 0 to 75 across all classes, the register selectors, and one valid flag for each selector. An illegal flag is also carried on the output path. With the allocation used here it never rises.

Top module: `exp_opcode_decoder`

## Requirements
- R1: When in_word[15:12] is 0x0 to 0xE, out_fmt is 0 and out_index equals in_word[15:12]. Selector 0 is in_word[11:8], selector 1 is in_word[7:4] and selector 2 is in_word[3:0].
- R2: When in_word[15:12] is 0xF and in_word[11:8] is 0x0 to 0xD, out_fmt is 1 and out_index is 15 + in_word[11:8]. Selector 0 is in_word[7:4] and selector 1 is in_word[3:0].
- R3: When in_word[15:8] is 0xFE, out_index is 29 + in_word[7:4]. When in_word[15:8] is 0xFF and in_word[7:4] is 0x0 to 0xE, out_index is 45 + in_word[7:4]. In both cases out_fmt is 2 and selector 0 is in_word[3:0].
- R4: When in_word[15:4] is 0xFFF, out_fmt is 3, out_index is 60 + in_word[3:0], and no selector is in use.
- R5: Selector k appears on out_regs[4k+3:4k]. Bit k of out_reg_vld is 1 exactly when the class uses field k; the set bits are the lowest 3 − out_fmt bits. Every unused selector reads 0.
- R6: out_valid equals in_valid as sampled at the previous rising clock edge. The decode of a word sampled with in_valid high appears on the outputs after that same edge.
- R7: At an edge where in_valid is low, out_fmt, out_index, out_regs, out_reg_vld and out_illegal keep their previous values.
- R8: out_illegal stays 0 for every input word, because exactly one class matches each pattern.
- R9: While rst_n is low (active-low, asynchronous), out_valid, out_fmt, out_index, out_regs, out_reg_vld and out_illegal are all 0.
- R10: Over all 65536 words, the counts per class are 61440, 3584, 496 and 16. Each instruction number is reached by 4096, 256, 16 or 1 words, according to its class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Registered decode valid |
| out_fmt | output | 2 | Class: 0 three regs, 1 two, 2 one, 3 none |
| out_index | output | 7 | Dense instruction number, 0 to 75 |
| out_regs | output | 12 | Register selectors, field k at bits 4k+3:4k |
| out_reg_vld | output | 3 | Per-selector valid flags |
| out_illegal | output | 1 | No single class matched |

## Verification
Every result depends on exactly one register, so every output is due at the first rising edge after a word is driven. The bench drives each word at a falling edge and samples all outputs 2 ns after the following rising edge. It compares them against a bench model, or against the previous decode when the strobe was low. An exhaustive sweep with the strobe held high runs one word per cycle under the same timing and builds the pattern counts. Those counts are checked once the sweep ends.

// File: rtl/exp_dec_pkg.sv
`timescale 1ns/1ps
package exp_dec_pkg;
  localparam int DEF_WORD_W     = 16;
  localparam int DEF_FIELD_W    = 4;
  localparam int DEF_NUM_FIELDS = 3;

  localparam int CNT_THREE = 15;
  localparam int CNT_TWO   = 14;
  localparam int CNT_ONE   = 31;
  localparam int CNT_ZERO  = 16;

  localparam int BASE_TWO  = CNT_THREE;
  localparam int BASE_ONE  = BASE_TWO + CNT_TWO;
  localparam int BASE_ZERO = BASE_ONE + CNT_ONE;
  localparam int TOTAL_OPS = BASE_ZERO + CNT_ZERO;
  localparam int DEF_IDX_W = $clog2(TOTAL_OPS);

  typedef enum logic [1:0] {
    FMT_THREE = 2'd0,
    FMT_TWO   = 2'd1,
    FMT_ONE   = 2'd2,
    FMT_ZERO  = 2'd3
  } fmt_e;
endpackage

// File: rtl/exp_dec_classify.sv
`timescale 1ns/1ps
module exp_dec_classify
  import exp_dec_pkg::*;
#(
  parameter int WORD_W  = DEF_WORD_W,
  parameter int FIELD_W = DEF_FIELD_W
) (
  input  logic [WORD_W-1:FIELD_W] prefix,
  output logic [3:0]              class_hit,
  output fmt_e                    fmt,
  output logic                    illegal
);
  localparam int ALL1 = (1 << FIELD_W) - 1;

  logic [FIELD_W-1:0] nib0, nib1, nib2;
  logic esc_first, esc_wide, esc_full;

  assign nib0 = prefix[WORD_W-1 -: FIELD_W];
  assign nib1 = prefix[WORD_W-1-FIELD_W -: FIELD_W];
  assign nib2 = prefix[WORD_W-1-2*FIELD_W -: FIELD_W];

  // escape chain: each all-ones level lengthens the opcode
  assign esc_first = &nib0;
  assign esc_wide  = esc_first && (int'(nib1) >= ALL1 - 1);
  assign esc_full  = esc_first && (&nib1) && (&nib2);

  assign class_hit[0] = !esc_first;
  assign class_hit[1] = esc_first && !esc_wide;
  assign class_hit[2] = esc_wide && !esc_full;
  assign class_hit[3] = esc_full;

  always_comb begin
    if (class_hit[3])      fmt = FMT_ZERO;
    else if (class_hit[2]) fmt = FMT_ONE;
    else if (class_hit[1]) fmt = FMT_TWO;
    else                   fmt = FMT_THREE;
  end

  assign illegal = ($countones(class_hit) != 1);
endmodule

// File: rtl/exp_dec_index.sv
`timescale 1ns/1ps
module exp_dec_index
  import exp_dec_pkg::*;
#(
  parameter int WORD_W  = DEF_WORD_W,
  parameter int FIELD_W = DEF_FIELD_W,
  parameter int IDX_W   = DEF_IDX_W
) (
  input  fmt_e              fmt,
  input  logic [WORD_W-1:0] word,
  output logic [IDX_W-1:0]  index
);
  localparam int ALL1 = (1 << FIELD_W) - 1;

  function automatic logic [IDX_W-1:0] dense_index(fmt_e f, logic [WORD_W-1:0] w);
    int n0, n1, n2, n3, r;
    n0 = int'(w[WORD_W-1 -: FIELD_W]);
    n1 = int'(w[WORD_W-1-FIELD_W -: FIELD_W]);
    n2 = int'(w[WORD_W-1-2*FIELD_W -: FIELD_W]);
    n3 = int'(w[FIELD_W-1:0]);
    case (f)
      FMT_THREE: r = n0;
      FMT_TWO:   r = BASE_TWO + n1;
      FMT_ONE:   r = (n1 == ALL1) ? BASE_ONE + ALL1 + 1 + n2 : BASE_ONE + n2;
      default:   r = BASE_ZERO + n3;
    endcase
    return IDX_W'(r);
  endfunction

  assign index = dense_index(fmt, word);
endmodule

// File: rtl/exp_dec_fields.sv
`timescale 1ns/1ps
module exp_dec_fields
  import exp_dec_pkg::*;
#(
  parameter int WORD_W     = DEF_WORD_W,
  parameter int FIELD_W    = DEF_FIELD_W,
  parameter int NUM_FIELDS = DEF_NUM_FIELDS
) (
  input  fmt_e                            fmt,
  input  logic [WORD_W-1:0]               word,
  output logic [NUM_FIELDS*FIELD_W-1:0]   regs,
  output logic [NUM_FIELDS-1:0]           reg_vld
);
  localparam int CNT_W = $clog2(NUM_FIELDS + 1);

  logic [CNT_W-1:0] n_ops;
  assign n_ops = CNT_W'(NUM_FIELDS) - CNT_W'(fmt);

  function automatic logic [FIELD_W-1:0] pick(logic [WORD_W-1:0] w, int slot);
    logic [FIELD_W-1:0] v;
    v = '0;
    for (int j = 0; j < NUM_FIELDS; j++)
      if (j == slot) v = w[j*FIELD_W +: FIELD_W];
    return v;
  endfunction

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    logic used;
    assign used = (k < int'(n_ops));
    assign reg_vld[k] = used;
    assign regs[k*FIELD_W +: FIELD_W] = used ? pick(word, int'(n_ops) - 1 - k) : '0;
  end
endmodule

// File: rtl/exp_dec_outreg.sv
`timescale 1ns/1ps
module exp_dec_outreg
  import exp_dec_pkg::*;
#(
  parameter int FIELD_W    = DEF_FIELD_W,
  parameter int NUM_FIELDS = DEF_NUM_FIELDS,
  parameter int IDX_W      = DEF_IDX_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          d_valid,
  input  fmt_e                          d_fmt,
  input  logic [IDX_W-1:0]              d_index,
  input  logic [NUM_FIELDS*FIELD_W-1:0] d_regs,
  input  logic [NUM_FIELDS-1:0]         d_reg_vld,
  input  logic                          d_illegal,
  output logic                          q_valid,
  output fmt_e                          q_fmt,
  output logic [IDX_W-1:0]              q_index,
  output logic [NUM_FIELDS*FIELD_W-1:0] q_regs,
  output logic [NUM_FIELDS-1:0]         q_reg_vld,
  output logic                          q_illegal
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_fmt     <= FMT_THREE;
      q_index   <= '0;
      q_regs    <= '0;
      q_reg_vld <= '0;
      q_illegal <= 1'b0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) begin
        q_fmt     <= d_fmt;
        q_index   <= d_index;
        q_regs    <= d_regs;
        q_reg_vld <= d_reg_vld;
        q_illegal <= d_illegal;
      end
    end
  end
endmodule

// File: rtl/exp_opcode_decoder.sv
`timescale 1ns/1ps
module exp_opcode_decoder
  import exp_dec_pkg::*;
#(
  parameter int WORD_W     = DEF_WORD_W,
  parameter int FIELD_W    = DEF_FIELD_W,
  parameter int NUM_FIELDS = DEF_NUM_FIELDS,
  parameter int IDX_W      = DEF_IDX_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [WORD_W-1:0]             in_word,
  output logic                          out_valid,
  output logic [1:0]                    out_fmt,
  output logic [IDX_W-1:0]              out_index,
  output logic [NUM_FIELDS*FIELD_W-1:0] out_regs,
  output logic [NUM_FIELDS-1:0]         out_reg_vld,
  output logic                          out_illegal
);
  logic [3:0]                    class_hit;
  fmt_e                          dec_fmt;
  logic                          dec_illegal;
  logic [IDX_W-1:0]              dec_index;
  logic [NUM_FIELDS*FIELD_W-1:0] dec_regs;
  logic [NUM_FIELDS-1:0]         dec_reg_vld;
  fmt_e                          q_fmt;

  exp_dec_classify #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_classify (
    .prefix    (in_word[WORD_W-1:FIELD_W]),
    .class_hit (class_hit),
    .fmt       (dec_fmt),
    .illegal   (dec_illegal)
  );

  exp_dec_index #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_index (
    .fmt   (dec_fmt),
    .word  (in_word),
    .index (dec_index)
  );

  exp_dec_fields #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_fields (
    .fmt     (dec_fmt),
    .word    (in_word),
    .regs    (dec_regs),
    .reg_vld (dec_reg_vld)
  );

  exp_dec_outreg #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .IDX_W(IDX_W)) u_outreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .d_valid   (in_valid),
    .d_fmt     (dec_fmt),
    .d_index   (dec_index),
    .d_regs    (dec_regs),
    .d_reg_vld (dec_reg_vld),
    .d_illegal (dec_illegal),
    .q_valid   (out_valid),
    .q_fmt     (q_fmt),
    .q_index   (out_index),
    .q_regs    (out_regs),
    .q_reg_vld (out_reg_vld),
    .q_illegal (out_illegal)
  );

  assign out_fmt = q_fmt;
endmodule

// File: rtl/exp_dec_chk.sv
`timescale 1ns/1ps
module exp_dec_chk
  import exp_dec_pkg::*;
#(
  parameter int FIELD_W    = DEF_FIELD_W,
  parameter int NUM_FIELDS = DEF_NUM_FIELDS,
  parameter int IDX_W      = DEF_IDX_W
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic [3:0]                    class_hit,
  input logic                          out_valid,
  input logic [1:0]                    out_fmt,
  input logic [IDX_W-1:0]              out_index,
  input logic [NUM_FIELDS*FIELD_W-1:0] out_regs,
  input logic [NUM_FIELDS-1:0]         out_reg_vld,
  input logic                          out_illegal
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R6
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R6
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_fmt) && $stable(out_index) && $stable(out_regs) && $stable(out_reg_vld))); // R7
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ($countones(class_hit) == 1)); // R8
  AST_NO_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !out_illegal); // R8
  AST_FLAG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (($countones(out_reg_vld) + int'(out_fmt)) == NUM_FIELDS)); // R5
  AST_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_reg_vld & (out_reg_vld + 1'b1)) == '0)); // R5
  AST_RANGE_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == 2'd0) |-> (int'(out_index) < BASE_TWO)); // R1
  AST_RANGE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == 2'd1) |-> (int'(out_index) >= BASE_TWO && int'(out_index) < BASE_ONE)); // R2
  AST_RANGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == 2'd2) |-> (int'(out_index) >= BASE_ONE && int'(out_index) < BASE_ZERO)); // R3
  AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == 2'd3) |-> (int'(out_index) >= BASE_ZERO && int'(out_index) < TOTAL_OPS)); // R4

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_unused
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !out_reg_vld[k] |-> (out_regs[k*FIELD_W +: FIELD_W] == '0)); // R5
  end
endmodule

bind exp_opcode_decoder exp_dec_chk #(
  .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .class_hit   (class_hit),
  .out_valid   (out_valid),
  .out_fmt     (out_fmt),
  .out_index   (out_index),
  .out_regs    (out_regs),
  .out_reg_vld (out_reg_vld),
  .out_illegal (out_illegal)
);

// File: tb/tb_exp_opcode_decoder.sv
`timescale 1ns/1ps
module tb_exp_opcode_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        out_valid;
  logic [1:0]  out_fmt;
  logic [6:0]  out_index;
  logic [11:0] out_regs;
  logic [2:0]  out_reg_vld;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0]  hold_f = '0;
  logic [6:0]  hold_i = '0;
  logic [11:0] hold_r = '0;
  logic [2:0]  hold_v = '0;

  int cls_cnt [4];
  int idx_cnt [76];
  bit tally = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  exp_opcode_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_fmt(out_fmt), .out_index(out_index),
    .out_regs(out_regs), .out_reg_vld(out_reg_vld), .out_illegal(out_illegal)
  );

  function automatic void model(input logic [15:0] w, output logic [1:0] f,
                                output logic [6:0] idx, output logic [11:0] r,
                                output logic [2:0] v);
    int hi, b, c, d;
    hi = int'(w[15:12]); b = int'(w[11:8]); c = int'(w[7:4]); d = int'(w[3:0]);
    if (hi != 15) begin
      f = 2'd0; idx = 7'(hi); r = {w[3:0], w[7:4], w[11:8]}; v = 3'b111;
    end else if (b < 14) begin
      f = 2'd1; idx = 7'(15 + b); r = {4'h0, w[3:0], w[7:4]}; v = 3'b011;
    end else if (b == 14) begin
      f = 2'd2; idx = 7'(29 + c); r = {8'h00, w[3:0]}; v = 3'b001;
    end else if (c != 15) begin
      f = 2'd2; idx = 7'(45 + c); r = {8'h00, w[3:0]}; v = 3'b001;
    end else begin
      f = 2'd3; idx = 7'(60 + d); r = '0; v = 3'b000;
    end
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic [15:0] w);
    logic [1:0] ef; logic [6:0] ei; logic [11:0] er; logic [2:0] ev;
    string tag;
    @(negedge clk);
    in_valid = v; in_word = w;
    @(posedge clk);
    #2;
    chk("R6", "out_valid", int'(out_valid), int'(v));
    if (v) begin
      model(w, ef, ei, er, ev);
      case (ef)
        2'd0: tag = "R1";
        2'd1: tag = "R2";
        2'd2: tag = "R3";
        default: tag = "R4";
      endcase
      chk(tag, "fmt", int'(out_fmt), int'(ef));
      chk(tag, "index", int'(out_index), int'(ei));
      chk("R5", "regs", int'(out_regs), int'(er));
      chk("R5", "reg_vld", int'(out_reg_vld), int'(ev));
      chk("R8", "illegal", int'(out_illegal), 0);
      hold_f = ef; hold_i = ei; hold_r = er; hold_v = ev;
      if (tally) begin
        cls_cnt[out_fmt]++;
        if (int'(out_index) < 76) idx_cnt[out_index]++;
      end
    end else begin
      chk("R7", "fmt hold", int'(out_fmt), int'(hold_f));
      chk("R7", "index hold", int'(out_index), int'(hold_i));
      chk("R7", "regs hold", int'(out_regs), int'(hold_r));
      chk("R7", "reg_vld hold", int'(out_reg_vld), int'(hold_v));
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] corners [12];
    int seed_dummy;
    seed_dummy = $urandom(32'h0dec0de5);
    foreach (cls_cnt[i]) cls_cnt[i] = 0;
    foreach (idx_cnt[i]) idx_cnt[i] = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9", "out_valid", int'(out_valid), 0);
    chk("R9", "out_fmt", int'(out_fmt), 0);
    chk("R9", "out_index", int'(out_index), 0);
    chk("R9", "out_regs", int'(out_regs), 0);
    chk("R9", "out_reg_vld", int'(out_reg_vld), 0);
    chk("R9", "out_illegal", int'(out_illegal), 0);
    rst_n = 1'b1;

    cycle(1'b0, 16'hABCD);  // R7: idle word ignored after reset

    corners = '{16'h0000, 16'hEFFF, 16'hF000, 16'hFDFF, 16'hFE00, 16'hFEFF,
                16'hFF00, 16'hFFEF, 16'hFFF0, 16'hFFFF, 16'hE123, 16'hF5A7};
    foreach (corners[i]) begin
      cycle(1'b1, corners[i]);
      if (i % 4 == 3) begin
        cycle(1'b0, 16'h1234);  // R7: gap with a different word
        cycle(1'b0, 16'hFFF9);
      end
    end

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] w;
      logic v;
      w = 16'($urandom);
      case ($urandom % 4)
        0: w[15:12] = 4'hF;
        1: w[15:8]  = 8'hFE | 8'($urandom % 2);
        2: w[15:4]  = 12'hFFF;
        default: ;
      endcase
      v = (($urandom % 4) != 0);
      cycle(v, w);
    end

    // R10: exhaustive sweep with strobe held high
    tally = 1'b1;
    for (int w = 0; w < 65536; w++) cycle(1'b1, 16'(w));
    tally = 1'b0;
    cycle(1'b0, 16'h0);

    chk("R10", "three-reg count", cls_cnt[0], 61440);
    chk("R10", "two-reg count", cls_cnt[1], 3584);
    chk("R10", "one-reg count", cls_cnt[2], 496);
    chk("R10", "no-reg count", cls_cnt[3], 16);
    for (int k = 0; k < 76; k++) begin
      int e;
      e = (k < 15) ? 4096 : (k < 29) ? 256 : (k < 60) ? 16 : 1;
      chk("R10", $sformatf("index %0d hits", k), idx_cnt[k], e);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule